// File: doc/BRIEF.md
# Dual-Mode PAM4/NRZ Serializer Front End

This block narrows a 32-bit parallel word into quarter-rate lanes for a serial transmitter that runs either four-level (PAM4) or two-level (NRZ) signalling. A cascade of 2:1 serializer stages halves the width at each step: 32 to 16, then 16 to 8, then 8 to 4. A mode input decides where the data is tapped. In PAM4 mode the 8-bit output of the second stage is presented as four symbol lanes, each an MSB/LSB pair. In NRZ mode the 4-bit output of the third stage is presented as four single-bit lanes. A final retimer register aligns every lane and the mode flag to one clock. Within each beat, lane 0 is the first unit interval and lane 3 the last.

The multiphase clocks of a real transmitter are modelled by one clock and per-stage enables. One clock cycle is one quarter-rate beat, so a word lasts 8 beats in NRZ mode and 4 beats in PAM4 mode. The block samples `data_i` on each word boundary, which `take_o` marks. A requested mode change only takes effect on a word boundary. The pipeline then drains the old word for one word period of the outgoing mode, and no new word is taken and no new beat is flagged valid during that period.

Top module: `dual_mode_ser_front`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `lanes_o` and `pam4_o` are all 0, and the block comes out of reset in NRZ mode.
- R2: With `mode_i` steady, `take_o` is high once every 8 cycles in NRZ mode and once every 4 cycles in PAM4 mode, and `data_i` is sampled at the rising edge where `take_o` is high.
- R3: In NRZ mode, beat b (b = 0..7) of a word w drives `lanes_o[l] = w[4b+l]` for l = 0..3, and `lanes_o[7:4]` is 0.
- R4: In PAM4 mode, beat b (b = 0..3) drives `lanes_o[2l+1:2l] = {w[8b+2l+1], w[8b+2l]}` for l = 0..3. The odd bit is the MSB, and an MSB never leaves the lane of its LSB.
- R5: Beat 0 of a word appears on the outputs after the 4th (NRZ) or 3rd (PAM4) rising edge following the edge that sampled the word. Later beats follow one per cycle.
- R6: Back-to-back words in one mode give an unbroken run of `valid_o`. `valid_o` is high only while a beat of a sampled word is shown.
- R7: When `mode_i` differs from the current mode at a word boundary, no word is taken at that boundary. The next word is taken one outgoing-mode word period later, in the new mode, and no beat is flagged valid between the two words.
- R8: A change of `mode_i` that is reverted before the next word boundary has no effect on the take timing or on the output beats.
- R9: `pam4_o` is 1 exactly when the shown beat belongs to a word taken in PAM4 mode (`mode_i` = 1 means PAM4, 0 means NRZ).
- R10: The first boundary after reset release is in the first cycle, and it adopts `mode_i` directly with no drain gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Beat clock, one quarter-rate beat per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | Requested mode: 1 = PAM4, 0 = NRZ |
| data_i | input | WORD_W | Parallel word, sampled when take_o is high |
| take_o | output | 1 | Word boundary: data_i is sampled at this edge |
| lanes_o | output | 2*LANES | Retimed lanes: LANES bit pairs (PAM4) or LANES bits in the low half (NRZ) |
| valid_o | output | 1 | The lanes carry a beat of a sampled word |
| pam4_o | output | 1 | Mode of the shown beat |

## Verification
The bench builds the block with its default 32-bit word and four lanes. This gives three stages, an 8-beat NRZ word and a 4-beat PAM4 word, so both mode taps, the bypass of the last stage in PAM4 mode and the drain gap in both directions are all reached. Every sampled word is expanded in the bench into a queue of beats with an exact due cycle. The outputs are then compared beat by beat, which covers bit order, lane pairing, latency and gaps together. Single-bit words at both ends, mode switches each way, a reverted mode glitch and a reset in mid-stream are driven on purpose.

// File: rtl/dmser_pkg.sv
package dmser_pkg;
  typedef enum logic {
    MODE_NRZ  = 1'b0,
    MODE_PAM4 = 1'b1
  } ser_mode_e;
endpackage

// File: rtl/dmser_ctrl.sv
module dmser_ctrl
  import dmser_pkg::*;
#(
  parameter int NST = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mode_i,
  output logic           take_o,
  output ser_mode_e      mode_o,
  output logic [NST-1:0] en_o,
  output logic [NST-1:0] sel_o,
  output logic           beat_vld_o
);
  localparam int CNT_W   = NST;
  localparam int LEN_NRZ = 1 << NST;
  localparam int LEN_PAM = 1 << (NST - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_m1;
  ser_mode_e        mode_q;
  ser_mode_e        mode_req;
  logic             first_q;
  logic             gap_q;
  logic             cyc_vld_q;
  logic [NST-1:0]   vld_sr_q;
  logic             boundary;
  logic             do_switch;

  assign mode_req  = ser_mode_e'(mode_i);
  assign len_m1    = (mode_q == MODE_PAM4) ? CNT_W'(LEN_PAM - 1) : CNT_W'(LEN_NRZ - 1);
  assign boundary  = first_q | (cnt_q == len_m1);
  assign do_switch = boundary & ~first_q & ~gap_q & (mode_req != mode_q);
  assign take_o    = boundary & ~do_switch;
  assign mode_o    = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      mode_q    <= MODE_NRZ;
      first_q   <= 1'b1;
      gap_q     <= 1'b0;
      cyc_vld_q <= 1'b0;
      vld_sr_q  <= '0;
    end else begin
      vld_sr_q <= {vld_sr_q[NST-2:0], cyc_vld_q};
      if (boundary) begin
        cnt_q   <= '0;
        first_q <= 1'b0;
        if (first_q || gap_q) begin
          mode_q    <= mode_req;
          gap_q     <= 1'b0;
          cyc_vld_q <= 1'b1;
        end else if (do_switch) begin
          // drain the old word for one outgoing word period
          gap_q     <= 1'b1;
          cyc_vld_q <= 1'b0;
        end else begin
          cyc_vld_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // Stage k captures 2^k times per word, first capture k-1 cycles after load.
  always_comb begin
    int u;
    int d;
    int sh;
    en_o  = '0;
    sel_o = '0;
    d     = 0;
    sh    = 0;
    u     = (mode_q == MODE_PAM4) ? NST - 1 : NST;
    for (int k = 1; k <= NST; k++) begin
      if (k <= u) begin
        d          = (int'(cnt_q) - (k - 1)) & ((1 << u) - 1);
        sh         = u - k;
        en_o[k-1]  = ((d & ((1 << sh) - 1)) == 0);
        sel_o[k-1] = (((d >> sh) & 1) != 0);
      end
    end
  end

  assign beat_vld_o = (mode_q == MODE_PAM4) ? vld_sr_q[NST-2] : vld_sr_q[NST-1];

  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary |=> $stable(mode_q));

  assert_take_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= len_m1);

  assert_gap_no_take_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_switch |=> !take_o && !cyc_vld_q);
endmodule

// File: rtl/dmser_stage.sv
module dmser_stage #(
  parameter int IN_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sel_i,
  input  logic [IN_W-1:0]   d_i,
  output logic [IN_W/2-1:0] q_o
);
  localparam int OUT_W = IN_W / 2;

  // 2:1 by halves keeps adjacent bit pairs together in every lane
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= sel_i ? d_i[IN_W-1:OUT_W] : d_i[OUT_W-1:0];
  end

  assert_stage_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/dmser_retimer.sv
module dmser_retimer
  import dmser_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ser_mode_e          mode_i,
  input  logic               vld_i,
  input  logic [2*LANES-1:0] pair_i,
  input  logic [LANES-1:0]   bit_i,
  output logic [2*LANES-1:0] lanes_o,
  output logic               valid_o,
  output logic               pam4_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lanes_o <= '0;
      valid_o <= 1'b0;
      pam4_o  <= 1'b0;
    end else begin
      lanes_o <= (mode_i == MODE_PAM4) ? pair_i : {{LANES{1'b0}}, bit_i};
      valid_o <= vld_i;
      pam4_o  <= (mode_i == MODE_PAM4);
    end
  end

  assert_run_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(valid_o) |-> $stable(pam4_o));
endmodule

// File: rtl/dual_mode_ser_front.sv
module dual_mode_ser_front
  import dmser_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANES  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mode_i,
  input  logic [WORD_W-1:0]  data_i,
  output logic               take_o,
  output logic [2*LANES-1:0] lanes_o,
  output logic               valid_o,
  output logic               pam4_o
);
  localparam int NST      = $clog2(WORD_W / LANES);
  localparam int CHAIN_W  = 2 * WORD_W - LANES;
  localparam int PAIR_OFF = 2 * WORD_W - (WORD_W >> (NST - 2));
  localparam int BIT_OFF  = 2 * WORD_W - (WORD_W >> (NST - 1));

  logic [WORD_W-1:0]  data_q;
  logic [CHAIN_W-1:0] chain;
  logic [NST-1:0]     en;
  logic [NST-1:0]     sel;
  ser_mode_e          mode_cur;
  logic               beat_vld;

  dmser_ctrl #(.NST(NST)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .take_o     (take_o),
    .mode_o     (mode_cur),
    .en_o       (en),
    .sel_o      (sel),
    .beat_vld_o (beat_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (take_o) data_q <= data_i;
  end

  // chain: input word at the bottom, then each stage output above it
  assign chain[WORD_W-1:0] = data_q;

  for (genvar k = 1; k <= NST; k++) begin : g_stage
    localparam int IW = WORD_W >> (k - 1);
    dmser_stage #(.IN_W(IW)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[k-1]),
      .sel_i  (sel[k-1]),
      .d_i    (chain[2*WORD_W-2*IW +: IW]),
      .q_o    (chain[2*WORD_W-IW +: IW/2])
    );
  end

  dmser_retimer #(.LANES(LANES)) u_retimer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_cur),
    .vld_i   (beat_vld),
    .pair_i  (chain[PAIR_OFF +: 2*LANES]),
    .bit_i   (chain[BIT_OFF +: LANES]),
    .lanes_o (lanes_o),
    .valid_o (valid_o),
    .pam4_o  (pam4_o)
  );

  assert_nrz_pad_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !pam4_o |-> lanes_o[2*LANES-1:LANES] == '0);
endmodule

// File: tb/dual_mode_ser_front_bench.sv
`timescale 1ns/1ps
module dual_mode_ser_front_bench;
  localparam int W     = 32;
  localparam int LN    = 4;
  localparam int NVEC  = 12;
  localparam int LIMIT = 3000;

  // {mode, word}; mode 1 = PAM4
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 32'h0000_0001}, {1'b0, 32'h8000_0000}, {1'b0, 32'hA5A5_F00F},
    {1'b0, 32'hFFFF_FFFF}, {1'b1, 32'h0000_0003}, {1'b1, 32'hC000_0000},
    {1'b1, 32'h1B1B_1B1B}, {1'b1, 32'h0123_4567}, {1'b0, 32'hDEAD_BEEF},
    {1'b1, 32'h89AB_CDEF}, {1'b1, 32'h7E7E_7E7E}, {1'b0, 32'h00FF_00FF}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_i = 1'b0;
  logic [W-1:0]  data_i = '0;
  logic          take_o;
  logic [2*LN-1:0] lanes_o;
  logic          valid_o;
  logic          pam4_o;

  dual_mode_ser_front #(.WORD_W(W), .LANES(LN)) u_dual_mode_ser_front (
    .clk_i, .rst_ni, .mode_i, .data_i, .take_o, .lanes_o, .valid_o, .pam4_o
  );

  always #5 clk_i = ~clk_i;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int due_q[$];
  logic [2*LN-1:0] lane_q[$];
  logic mode_q[$];
  bit   have_last = 0;
  int   last_cyc  = 0;
  logic last_m    = 0;
  string sp_tag   = "";

  function automatic int beats(input logic m);
    return m ? 4 : 8;
  endfunction

  function automatic int lat(input logic m);
    return m ? 4 : 5;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic record(input logic m, input logic [W-1:0] w);
    logic [2*LN-1:0] v;
    if (have_last) begin
      int exp_sp;
      string tg;
      exp_sp = (m == last_m) ? beats(last_m) : 2 * beats(last_m);
      tg = (sp_tag != "") ? sp_tag : ((m == last_m) ? "R2" : "R7");
      chk(cyc - last_cyc == exp_sp, tg, "take spacing", cyc - last_cyc, exp_sp);
    end
    for (int b = 0; b < beats(m); b++) begin
      v = '0;
      for (int l = 0; l < LN; l++) begin
        if (m) v[2*l +: 2] = w[8*b + 2*l +: 2];
        else   v[l]       = w[4*b + l];
      end
      due_q.push_back(cyc + lat(m) + b);
      lane_q.push_back(v);
      mode_q.push_back(m);
    end
    last_cyc  = cyc;
    last_m    = m;
    have_last = 1;
  endtask

  task automatic check_out();
    if (!rst_ni) begin
      chk(valid_o == 1'b0 && lanes_o == '0 && pam4_o == 1'b0, "R1", "outputs in reset",
          {valid_o, pam4_o, lanes_o}, 0);
      return;
    end
    while (due_q.size() > 0 && due_q[0] < cyc) begin
      chk(0, "R6", "beat missed at cycle", cyc, due_q[0]);
      void'(due_q.pop_front()); void'(lane_q.pop_front()); void'(mode_q.pop_front());
    end
    if (valid_o) begin
      if (due_q.size() == 0 || due_q[0] != cyc) begin
        chk(0, "R6", "valid without due beat", cyc, (due_q.size() > 0) ? due_q[0] : 0);
      end else begin
        chk(lanes_o == lane_q[0], mode_q[0] ? "R4" : "R3", "lane data", lanes_o, lane_q[0]);
        chk(pam4_o == mode_q[0], "R9", "beat mode", pam4_o, mode_q[0]);
        void'(due_q.pop_front()); void'(lane_q.pop_front()); void'(mode_q.pop_front());
      end
    end else if (due_q.size() > 0 && due_q[0] == cyc) begin
      chk(0, "R5", "beat not shown at due cycle", cyc, due_q[0]);
      void'(due_q.pop_front()); void'(lane_q.pop_front()); void'(mode_q.pop_front());
    end
  endtask

  task automatic step(output bit took);
    #1;
    took = rst_ni && take_o;
    if (took) record(mode_i, data_i);
    @(negedge clk_i);
    cyc++;
    if (cyc > LIMIT) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, LIMIT);
      summary();
      $finish;
    end
    check_out();
  endtask

  task automatic send(input logic m, input logic [W-1:0] w);
    bit t;
    mode_i = m;
    data_i = w;
    do step(t); while (!t);
  endtask

  task automatic clear_exp();
    due_q.delete(); lane_q.delete(); mode_q.delete();
    have_last = 0;
  endtask

  initial begin
    bit t;
    @(negedge clk_i);
    check_out();                       // R1 during reset
    step(t); step(t);
    rst_ni = 1'b1;
    mode_i = 1'b0;
    #1 chk(take_o == 1'b1, "R10", "take in first cycle after reset", take_o, 1);

    // table walk: NRZ run, switch to PAM4, back and forth
    for (int i = 0; i < NVEC; i++) send(VEC[i][32], VEC[i][31:0]);

    // R8: reverted mode glitch mid-word (cnt 0 and 1, away from boundary)
    sp_tag = "R8";
    mode_i = 1'b1; data_i = 32'h3C3C_A55A;
    step(t); chk(!t, "R8", "no take during glitch", t, 0);
    step(t); chk(!t, "R8", "no take during glitch", t, 0);
    send(1'b0, 32'h3C3C_A55A);
    sp_tag = "";
    send(1'b0, 32'h1234_5678);

    // R1 and R10: reset in mid-stream, restart straight into PAM4
    rst_ni = 1'b0;
    #1 chk(valid_o == 1'b0 && lanes_o == '0 && pam4_o == 1'b0, "R1", "async clear",
           {valid_o, pam4_o, lanes_o}, 0);
    clear_exp();
    step(t); step(t);
    rst_ni = 1'b1;
    mode_i = 1'b1; data_i = 32'hF0E1_D2C3;
    #1 chk(take_o == 1'b1, "R10", "first boundary adopts mode without gap", take_o, 1);
    send(1'b1, 32'hF0E1_D2C3);
    send(1'b1, 32'h8000_0001);
    send(1'b0, 32'h8000_0001);

    // drain: let the last word's beats out
    for (int i = 0; i < 14; i++) step(t);

    summary();
    $finish;
  end
endmodule